// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between a clocked request port and an external byte-wide asynchronous static RAM with 8192 locations. A user issues a single-cycle request with a direction bit, an address and, for a store, a data byte. The block then runs a fixed four-state sequence. The states are idle, setup, strobe and hold. The sequence steps the memory's select, output-enable and write-enable lines, and it drives or releases the shared bidirectional data bus.

Every control line and the bus drive enable come from flip-flops. The address is held in a register from the moment a request is taken until the access ends. Stores commit on the rising edge of the write strobe, while address and data are still held. Loads sample the bus into a result register after the output enable has been active for two cycles. A one-cycle completion pulse marks the end of each access. The second chip enable, which is active high, is tied to its enabling level.

Top module: `sram_bus_ctl`

## Requirements
- R1: After reset, the chip-select (active low), output-enable (active low) and write-enable (active low) outputs are all high, and the completion pulse is low.
- R2: The active-high chip-enable output is held at 1 at all times.
- R3: For a store, write-enable is low for exactly one cycle, the middle cycle of the access. The controller drives the store byte on the data bus in all three cycles of the access, so the byte is stable when write-enable rises and the memory commits it.
- R4: The memory address output equals the accepted request address and does not change while chip-select is low.
- R5: For a load, output-enable is low for exactly two cycles and write-enable stays high. The result output then carries the byte stored at the requested address.
- R6: The result output changes only together with the completion pulse of a load. A store leaves it unchanged.
- R7: The completion pulse is high for exactly one cycle: the third cycle after the cycle in which the request was sampled in idle.
- R8: A request raised while an access is in progress is ignored. It causes no extra completion pulse and no memory write.
- R9: The controller never drives the data bus while output-enable is low. Output-enable has been high for at least one cycle before the controller starts driving.
- R10: Chip-select is low for exactly three consecutive cycles per access and returns high for at least one cycle between accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, sampled in idle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | AW (13) | Request address |
| req_wdata | input | DW (8) | Store data |
| rsp_rdata | output | DW (8) | Last loaded byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| mem_addr | output | AW (13) | Memory address |
| mem_dq | inout | DW (8) | Bidirectional memory data bus |
| mem_ce1_n | output | 1 | Chip select, active low |
| mem_ce2 | output | 1 | Chip enable, active high, tied to 1 |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |

## Verification
The properties assume that reset is applied before the first access. They also assume that the memory drives the bus only while it is selected with output-enable low and write-enable high. The bench's behavioural memory obeys exactly that rule and commits a store on the rising write strobe. Stimulus changes requests only between clock edges. It waits for each completion pulse before starting the next access, except in deliberate busy-time pokes that exercise the ignore rule.

// File: rtl/sram_bus_pkg.sv
package sram_bus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2,
        ST_HOLD   = 2'd3
    } acc_state_t;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic drive;
        logic done;
    } bus_ctl_t;

    localparam bus_ctl_t CTL_QUIET = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1,
                                       drive: 1'b0, done: 1'b0};

    function automatic acc_state_t step_state(acc_state_t st, logic req);
        acc_state_t nx;
        case (st)
            ST_IDLE:   nx = req ? ST_SETUP : ST_IDLE;
            ST_SETUP:  nx = ST_STROBE;
            ST_STROBE: nx = ST_HOLD;
            default:   nx = ST_IDLE;
        endcase
        return nx;
    endfunction

    function automatic bus_ctl_t ctl_for(acc_state_t st, logic wr);
        bus_ctl_t c;
        c = CTL_QUIET;
        case (st)
            ST_SETUP: begin
                c.ce_n  = 1'b0;
                c.oe_n  = wr;
                c.drive = wr;
            end
            ST_STROBE: begin
                c.ce_n  = 1'b0;
                c.oe_n  = wr;
                c.we_n  = ~wr;
                c.drive = wr;
            end
            ST_HOLD: begin
                c.ce_n  = 1'b0;
                c.drive = wr;
                c.done  = 1'b1;
            end
            default: c = CTL_QUIET;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sram_bus_seq.sv
module sram_bus_seq
    import sram_bus_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       req_write,
    output logic       accept,
    output logic       capture,
    output bus_ctl_t   ctl_q
);
    acc_state_t state_q, state_d;
    logic       wr_q, wr_d;

    assign accept  = (state_q == ST_IDLE) && req_valid;
    assign state_d = step_state(state_q, req_valid);
    assign wr_d    = accept ? req_write : wr_q;
    // a load samples the bus on the edge that leaves the strobe state
    assign capture = (state_q == ST_STROBE) && !wr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            wr_q    <= 1'b0;
            ctl_q   <= CTL_QUIET;
        end else begin
            state_q <= state_d;
            wr_q    <= wr_d;
            ctl_q   <= ctl_for(state_d, wr_d);
        end
    end
endmodule

// File: rtl/sram_bus_path.sv
module sram_bus_path #(
    parameter int AW = 13,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic          capture,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] bus_in,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output logic [DW-1:0] rdata_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (capture) begin
                rdata_q <= bus_in;
            end
        end
    end
endmodule

// File: rtl/sram_bus_ctl.sv
module sram_bus_ctl
    import sram_bus_pkg::*;
#(
    parameter int AW = 13,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic [DW-1:0] rsp_rdata,
    output logic          rsp_done,
    output logic [AW-1:0] mem_addr,
    inout  wire  [DW-1:0] mem_dq,
    output logic          mem_ce1_n,
    output logic          mem_ce2,
    output logic          mem_oe_n,
    output logic          mem_we_n
);
    bus_ctl_t      ctl_q;
    logic          accept;
    logic          capture;
    logic          bus_drive;
    logic [DW-1:0] wdata_q;

    sram_bus_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .accept    (accept),
        .capture   (capture),
        .ctl_q     (ctl_q)
    );

    sram_bus_path #(.AW(AW), .DW(DW)) u_path (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .bus_in    (mem_dq),
        .addr_q    (mem_addr),
        .wdata_q   (wdata_q),
        .rdata_q   (rsp_rdata)
    );

    assign bus_drive = ctl_q.drive;
    assign mem_dq    = bus_drive ? wdata_q : {DW{1'bz}};
    assign mem_ce1_n = ctl_q.ce_n;
    assign mem_ce2   = 1'b1;
    assign mem_oe_n  = ctl_q.oe_n;
    assign mem_we_n  = ctl_q.we_n;
    assign rsp_done  = ctl_q.done;
endmodule

// File: rtl/sram_bus_ctl_chk.sv
module sram_bus_ctl_chk #(
    parameter int AW = 13,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ce1_n,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic          rsp_done,
    input logic [DW-1:0] rsp_rdata,
    input logic          drive_en
);
    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst) !mem_we_n |=> mem_we_n); // R3
    AST_WE_SELECTED: assert property (@(posedge clk) disable iff (rst) !mem_we_n |-> (!mem_ce1_n && mem_oe_n && drive_en)); // R3
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst) (!mem_ce1_n && !$past(mem_ce1_n)) |-> $stable(mem_addr)); // R4
    AST_RDATA_STEADY: assert property (@(posedge clk) disable iff (rst) !$stable(rsp_rdata) |-> rsp_done); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) rsp_done |=> !rsp_done); // R7
    AST_NO_FIGHT: assert property (@(posedge clk) disable iff (rst) drive_en |-> mem_oe_n); // R9
    AST_OE_GAP: assert property (@(posedge clk) disable iff (rst) $rose(drive_en) |-> $past(mem_oe_n)); // R9
    AST_DESELECT_GAP: assert property (@(posedge clk) disable iff (rst) rsp_done |=> mem_ce1_n); // R10
endmodule

bind sram_bus_ctl sram_bus_ctl_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_ce1_n (mem_ce1_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .rsp_done  (rsp_done),
    .rsp_rdata (rsp_rdata),
    .drive_en  (bus_drive)
);

// File: tb/sim_sram_bus_ctl.sv
module sim_sram_bus_ctl;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 13;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [DW-1:0] rsp_rdata;
    logic          rsp_done;
    logic [AW-1:0] mem_addr;
    wire  [DW-1:0] mem_dq;
    logic          mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] sram    [DEPTH];
    logic [DW-1:0] ref_mem [DEPTH];
    logic [DW-1:0] last_rd = '0;
    logic          armed = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_bus_ctl #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .rsp_done(rsp_done), .mem_addr(mem_addr), .mem_dq(mem_dq),
        .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n)
    );

    // behavioural asynchronous memory
    assign mem_dq = (!mem_ce1_n && mem_ce2 && !mem_oe_n && mem_we_n) ? sram[mem_addr] : {DW{1'bz}};
    always @(posedge mem_we_n) begin
        if (armed && !mem_ce1_n && mem_ce2) sram[mem_addr] <= mem_dq;
    end

    function automatic logic [DW-1:0] seed_byte(int a);
        return DW'(a * 37 + 11);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit poke);
        int ce_lo = 0;
        int oe_lo = 0;
        int we_lo = 0;
        int done_at = 0;
        int dones = 0;
        bit bus_ok = 1'b1;
        bit addr_ok = 1'b1;
        bit ce2_ok = 1'b1;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        for (int i = 1; i <= 3; i++) begin
            @(negedge clk);
            if (i == 1) begin
                if (poke) begin
                    req_write = ~wr; req_addr = a ^ 13'h155; req_wdata = ~d;
                end else req_valid = 1'b0;
            end
            if (i == 2) req_valid = 1'b0;
            ce_lo += int'(!mem_ce1_n);
            oe_lo += int'(!mem_oe_n);
            we_lo += int'(!mem_we_n);
            if (mem_addr != a) addr_ok = 1'b0;
            if (!mem_ce2) ce2_ok = 1'b0;
            if (wr && mem_dq !== d) bus_ok = 1'b0;
            if (rsp_done) begin
                dones++;
                if (done_at == 0) done_at = i;
            end
        end
        chk(done_at == 3, "R7 done cycle", done_at, 3);
        chk(ce_lo == 3, "R10 select cycles", ce_lo, 3);
        chk(addr_ok, "R4 address held", int'(mem_addr), int'(a));
        chk(ce2_ok, "R2 ce2 high", int'(mem_ce2), 1);
        if (wr) begin
            chk(we_lo == 1, "R3 write strobe cycles", we_lo, 1);
            chk(oe_lo == 0, "R9 oe during store", oe_lo, 0);
            chk(bus_ok, "R3 bus carries store byte", int'(mem_dq), int'(d));
            chk(rsp_rdata == last_rd, "R6 result kept over store", int'(rsp_rdata), int'(last_rd));
            ref_mem[a] = d;
        end else begin
            chk(we_lo == 0, "R5 no write strobe on load", we_lo, 0);
            chk(oe_lo == 2, "R5 oe cycles", oe_lo, 2);
            chk(rsp_rdata == ref_mem[a], "R5 load data", int'(rsp_rdata), int'(ref_mem[a]));
            last_rd = ref_mem[a];
        end
        @(negedge clk);
        if (rsp_done) dones++;
        chk(dones == 1, "R8 R7 single completion", dones, 1);
        chk(mem_ce1_n && mem_oe_n && mem_we_n, "R10 deselected after access",
            int'({mem_ce1_n, mem_oe_n, mem_we_n}), 7);
        chk(rsp_rdata == last_rd, "R6 result stable after done", int'(rsp_rdata), int'(last_rd));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < DEPTH; i++) begin
            sram[i]    = seed_byte(i);
            ref_mem[i] = seed_byte(i);
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        armed = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(mem_ce1_n && mem_oe_n && mem_we_n && !rsp_done, "R1 idle controls after reset",
            int'({mem_ce1_n, mem_oe_n, mem_we_n, rsp_done}), 14);
        chk(rsp_rdata == '0, "R1 result cleared", int'(rsp_rdata), 0);
        chk(mem_ce2 == 1'b1, "R2 ce2 high at reset", int'(mem_ce2), 1);
        // directed corners
        access(1'b0, 13'h0000, 8'h00, 1'b0);
        access(1'b1, 13'h0000, 8'hFF, 1'b0);
        access(1'b0, 13'h0000, 8'h00, 1'b0);
        access(1'b1, 13'h1FFF, 8'h00, 1'b0);
        access(1'b0, 13'h1FFF, 8'h00, 1'b0);
        access(1'b1, 13'h0AAA, 8'h5A, 1'b0);
        access(1'b1, 13'h0AAB, 8'hA5, 1'b0);
        access(1'b0, 13'h0AAA, 8'h00, 1'b0);
        access(1'b0, 13'h0AAB, 8'h00, 1'b0);
        // R8 poke while busy: load whose busy-time request would store elsewhere
        access(1'b0, 13'h0100, 8'h33, 1'b1);
        access(1'b0, 13'h0100 ^ 13'h155, 8'h00, 1'b0);
        access(1'b1, 13'h0200, 8'h77, 1'b1);
        access(1'b0, 13'h0200 ^ 13'h155, 8'h00, 1'b0);
        access(1'b0, 13'h0200, 8'h00, 1'b0);
        // constrained random traffic over a small address window
        for (int n = 0; n < 300; n++) begin
            logic [AW-1:0] ra;
            ra = AW'($urandom_range(0, 31)) | (($urandom_range(0, 1) != 0) ? 13'h1FE0 : 13'h0000);
            access(logic'($urandom_range(0, 1)), ra, DW'($urandom), 1'b0);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule